// File: doc/BRIEF.md
# Private interrupt pending logic

This block holds the pending state of the 32 interrupts that are private to one processor. The lower 16 are raised by software; the upper 16 follow peripheral input lines. Each peripheral line can be set to edge or level mode. An edge-mode line latches pending on a rising transition. A level-mode line reports pending while the line is high, in addition to anything already latched. Software can set or clear any latch bit directly through per-bit strobes from a register bank.

A software interrupt request carries a requested group, a target number in 0..15 and a non-secure flag. It is accepted only when its group agrees with the target's configured group. A request for the secure half of group 1 may also land on a group 0 target. A non-secure request made while security is enabled must also pass a 2-bit permission field for that target. An accepted request sets the target's latch.

Each latch bit is a two-state machine. LT_IDLE moves to LT_PEND on any set source (software set, edge, accepted request) when no clear is present in that cycle. LT_PEND moves to LT_IDLE on a clear strobe. Every other case stays in the current state. The pending output is decoded from these states and ORed with the sampled level of level-mode lines.

Top module: `pip_pending`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, all latches are LT_IDLE, the sampled line levels are 0 and `pend_o` is all zero.
- R2: When peripheral line k (interrupt 16+k) is in edge mode (`edge_cfg[k]`=1) and `line_lvl[k]` is 1 at a clock edge after being 0 at the previous one, the latch of interrupt 16+k is set. `pend_o` shows it after that edge. A line that stays high or falls sets nothing.
- R3: A set latch stays set until a clear strobe arrives, whatever the line does.
- R4: `pend_o[16+k]` is the latch OR (the line level sampled at the last edge AND `edge_cfg[k]`=0). Bits 0..15 show only the latch.
- R5: A 1 in `sw_set[i]` at a clock edge sets the latch of interrupt i.
- R6: A 1 in `sw_clr[i]` at a clock edge leaves latch i clear, even when a software set, an edge or an accepted request targets i in the same cycle.
- R7: Group codes are 0 = group 0, 1 = secure group 1, 2 = non-secure group 1, 3 = none. Target i is configured as follows. `grp_cfg[i]`=1 gives code 2. `grp_cfg[i]`=0 with `mod_cfg[i]`=1 gives code 1. Both 0 gives code 0. When `sec_off`=1, `mod_cfg` is ignored and `grp_cfg[i]`=0 gives code 0. A request with code 1 aimed at a code 0 target is handled as code 0.
- R8: A request whose group, after R7, differs from the target's group is dropped and sets nothing. A request with code 3 is always dropped.
- R9: Target i's permission field is `nsacc[2i+1:2i]`. The check applies only when `sgi_ns`=1 and `sec_off`=0. Under the check, a code 0 target needs a value of at least 1 and a code 1 target needs at least 2; otherwise the request is dropped. Code 2 targets are never blocked by the field.
- R10: An accepted request (`sgi_vld`=1) sets the latch of target `sgi_id` at that edge, and only that latch.
- R11: With `sgi_vld`=0, the request fields have no effect on any latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_lvl | input | 16 | Peripheral line levels, bit k feeds interrupt 16+k |
| edge_cfg | input | 16 | 1 = edge mode, 0 = level mode, bit k for interrupt 16+k |
| sw_set | input | 32 | Software set strobes, one per interrupt |
| sw_clr | input | 32 | Software clear strobes, one per interrupt |
| sgi_vld | input | 1 | Software request valid |
| sgi_grp | input | 2 | Requested group code |
| sgi_id | input | 4 | Target interrupt number |
| sgi_ns | input | 1 | Request is non-secure |
| grp_cfg | input | 16 | Group bit per software interrupt |
| mod_cfg | input | 16 | Group modifier bit per software interrupt |
| nsacc | input | 32 | 2-bit non-secure permission per software interrupt |
| sec_off | input | 1 | Security disabled |
| pend_o | output | 32 | Effective pending vector |

## Verification
Edge-mode lines are driven through rise, hold-high and fall. This separates a true rising-transition detector from one that triggers on level or on either transition. Level-mode lines are toggled to show that the level term follows the sampled input while the latch does not. Software requests cover every group pairing and permission value, with and without security. This tells group reconciliation apart from plain equality, and permission thresholds from each other. Clear strobes collide with each set source to show that clear wins, and a long random phase compares every cycle against the model.

// File: rtl/pip_pkg.sv
package pip_pkg;

    typedef enum logic [1:0] {
        GRP_G0   = 2'd0,
        GRP_G1S  = 2'd1,
        GRP_G1NS = 2'd2,
        GRP_NONE = 2'd3
    } pip_grp_e;

    typedef enum logic {
        LT_IDLE = 1'b0,
        LT_PEND = 1'b1
    } pip_lt_e;

    // Configured group of one software interrupt (R7)
    function automatic pip_grp_e cfg_group(input logic grp_bit,
                                           input logic mod_bit,
                                           input logic sec_dis);
        if (grp_bit)
            return GRP_G1NS;
        else if (mod_bit && !sec_dis)
            return GRP_G1S;
        else
            return GRP_G0;
    endfunction

endpackage

// File: rtl/pip_sgi_filter.sv
module pip_sgi_filter
    import pip_pkg::*;
#(
    parameter int NUM_SGI = 16,
    localparam int IDW = $clog2(NUM_SGI)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_vld,
    input  logic [1:0]         req_grp,
    input  logic [IDW-1:0]     req_id,
    input  logic               req_ns,
    input  logic [NUM_SGI-1:0] grp_bits,
    input  logic [NUM_SGI-1:0] mod_bits,
    input  logic [2*NUM_SGI-1:0] perm_bits,
    input  logic               sec_dis,
    output logic [NUM_SGI-1:0] set_vec
);

    pip_grp_e   tgt_grp;
    pip_grp_e   eff_grp;
    logic [1:0] perm;
    logic       grp_ok;
    logic       perm_ok;
    logic       accept;

    always_comb begin
        tgt_grp = cfg_group(grp_bits[req_id], mod_bits[req_id], sec_dis);
        eff_grp = pip_grp_e'(req_grp);
        if (eff_grp == GRP_G1S && tgt_grp == GRP_G0)
            eff_grp = GRP_G0;
        grp_ok  = (eff_grp == tgt_grp);
        perm    = perm_bits[2*req_id +: 2];
        perm_ok = 1'b1;
        if (req_ns && !sec_dis) begin
            unique case (tgt_grp)
                GRP_G0:  perm_ok = (perm >= 2'd1);
                GRP_G1S: perm_ok = (perm >= 2'd2);
                default: perm_ok = 1'b1;
            endcase
        end
        accept  = req_vld && grp_ok && perm_ok;
        set_vec = accept ? (NUM_SGI'(1) << req_id) : '0;
    end

    // R11: no valid request, no set
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |-> (set_vec == '0));

    // R10: at most the one target is set
    a_r10_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(set_vec) && ((set_vec & ~(NUM_SGI'(1) << req_id)) == '0));

    // R8: a non-secure group 1 request never lands on a group 0 target
    a_r8_ns_on_g0_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (req_grp == 2'd2 && !grp_bits[req_id]) |-> (set_vec == '0));

    // R9: secure-group-1 target with a low permission refuses non-secure requests
    a_r9_perm_low_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ns && !sec_dis && !grp_bits[req_id] && mod_bits[req_id]
         && perm_bits[2*req_id + 1] == 1'b0) |-> (set_vec == '0));

endmodule

// File: rtl/pip_line_sync.sv
module pip_line_sync #(
    parameter int NUM_LINE = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_LINE-1:0] lvl_in,
    output logic [NUM_LINE-1:0] lvl_q,
    output logic [NUM_LINE-1:0] rise
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            lvl_q <= '0;
        else
            lvl_q <= lvl_in;
    end

    assign rise = lvl_in & ~lvl_q;

    // R4: the sampled level follows the input one edge later
    a_r4_sample_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (lvl_q == $past(lvl_in)));

endmodule

// File: rtl/pip_latch_bank.sv
module pip_latch_bank
    import pip_pkg::*;
#(
    parameter int NUM_INT = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_INT-1:0] set_vec,
    input  logic [NUM_INT-1:0] clr_vec,
    output logic [NUM_INT-1:0] pend
);

    for (genvar i = 0; i < NUM_INT; i++) begin : g_bit
        pip_lt_e st_q;
        pip_lt_e st_d;

        always_comb begin
            st_d = st_q;
            unique case (st_q)
                LT_IDLE: if (set_vec[i] && !clr_vec[i]) st_d = LT_PEND;
                LT_PEND: if (clr_vec[i])                st_d = LT_IDLE;
                default: st_d = LT_IDLE;
            endcase
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                st_q <= LT_IDLE;
            else
                st_q <= st_d;
        end

        always_comb begin
            pend[i] = (st_q == LT_PEND);
        end
    end

    // R6: a clear strobe always leaves its bit clear
    a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_vec) |=> ((pend & $past(clr_vec)) == '0));

    // R3: bits with no strobe keep their value
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((pend ^ $past(pend)) & ~$past(set_vec | clr_vec)) == '0));

    // R5: a set without clear leaves the bit pending
    a_r5_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_vec & ~clr_vec)) |=> ((pend & $past(set_vec & ~clr_vec))
                                      == $past(set_vec & ~clr_vec)));

endmodule

// File: rtl/pip_pending.sv
module pip_pending
    import pip_pkg::*;
#(
    parameter int NUM_SGI  = 16,
    parameter int NUM_LINE = 16,
    localparam int NUM_INT = NUM_SGI + NUM_LINE,
    localparam int IDW     = $clog2(NUM_SGI)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINE-1:0]  line_lvl,
    input  logic [NUM_LINE-1:0]  edge_cfg,
    input  logic [NUM_INT-1:0]   sw_set,
    input  logic [NUM_INT-1:0]   sw_clr,
    input  logic                 sgi_vld,
    input  logic [1:0]           sgi_grp,
    input  logic [IDW-1:0]       sgi_id,
    input  logic                 sgi_ns,
    input  logic [NUM_SGI-1:0]   grp_cfg,
    input  logic [NUM_SGI-1:0]   mod_cfg,
    input  logic [2*NUM_SGI-1:0] nsacc,
    input  logic                 sec_off,
    output logic [NUM_INT-1:0]   pend_o
);

    logic [NUM_SGI-1:0]  sgi_set;
    logic [NUM_LINE-1:0] lvl_q;
    logic [NUM_LINE-1:0] rise;
    logic [NUM_LINE-1:0] edge_set;
    logic [NUM_INT-1:0]  set_all;
    logic [NUM_INT-1:0]  latch;

    pip_sgi_filter #(.NUM_SGI(NUM_SGI)) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_vld  (sgi_vld),
        .req_grp  (sgi_grp),
        .req_id   (sgi_id),
        .req_ns   (sgi_ns),
        .grp_bits (grp_cfg),
        .mod_bits (mod_cfg),
        .perm_bits(nsacc),
        .sec_dis  (sec_off),
        .set_vec  (sgi_set)
    );

    pip_line_sync #(.NUM_LINE(NUM_LINE)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_in(line_lvl),
        .lvl_q (lvl_q),
        .rise  (rise)
    );

    assign edge_set = rise & edge_cfg;
    assign set_all  = sw_set | {edge_set, sgi_set};

    pip_latch_bank #(.NUM_INT(NUM_INT)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_vec(set_all),
        .clr_vec(sw_clr),
        .pend   (latch)
    );

    assign pend_o = latch | {lvl_q & ~edge_cfg, {NUM_SGI{1'b0}}};

    // R2: a rising edge-mode line with no clear is pending after the edge
    a_r2_edge_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (|(line_lvl & ~lvl_q & edge_cfg & ~sw_clr[NUM_INT-1:NUM_SGI]))
        |=> ((pend_o[NUM_INT-1:NUM_SGI]
              & $past(line_lvl & ~lvl_q & edge_cfg & ~sw_clr[NUM_INT-1:NUM_SGI]))
             == $past(line_lvl & ~lvl_q & edge_cfg & ~sw_clr[NUM_INT-1:NUM_SGI])));

    // R4: a high level-mode line shows pending one edge later
    a_r4_level_seen: assert property (@(posedge clk) disable iff (!rst_n)
        (|(line_lvl & ~edge_cfg))
        |=> (($past(line_lvl & ~edge_cfg) & ~edge_cfg
              & ~pend_o[NUM_INT-1:NUM_SGI]) == '0));

endmodule

// File: tb/sim_pip_pending.sv
module sim_pip_pending;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] line_lvl = '0;
    logic [15:0] edge_cfg = '0;
    logic [31:0] sw_set = '0;
    logic [31:0] sw_clr = '0;
    logic        sgi_vld = 1'b0;
    logic [1:0]  sgi_grp = '0;
    logic [3:0]  sgi_id = '0;
    logic        sgi_ns = 1'b0;
    logic [15:0] grp_cfg = '0;
    logic [15:0] mod_cfg = '0;
    logic [31:0] nsacc = '0;
    logic        sec_off = 1'b0;
    logic [31:0] pend_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    pip_pending u0 (
        .clk(clk), .rst_n(rst_n), .line_lvl(line_lvl), .edge_cfg(edge_cfg),
        .sw_set(sw_set), .sw_clr(sw_clr), .sgi_vld(sgi_vld), .sgi_grp(sgi_grp),
        .sgi_id(sgi_id), .sgi_ns(sgi_ns), .grp_cfg(grp_cfg), .mod_cfg(mod_cfg),
        .nsacc(nsacc), .sec_off(sec_off), .pend_o(pend_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference model
    bit [31:0] m_latch = '0;
    bit [15:0] m_lvl = '0;

    function automatic int m_group(int i);
        if (grp_cfg[i]) return 2;
        if (sec_off) return 0;
        return mod_cfg[i] ? 1 : 0;
    endfunction

    function automatic bit m_accept();
        int t, r, p;
        bit ok;
        if (!sgi_vld) return 1'b0;
        t = m_group(int'(sgi_id));
        r = int'(sgi_grp);
        if (r == 1 && t == 0) r = 0;
        ok = (r == t);
        if (ok && sgi_ns && !sec_off) begin
            p = int'(nsacc[2*sgi_id +: 2]);
            if (t == 0) ok = (p >= 1);
            else if (t == 1) ok = (p >= 2);
        end
        return ok;
    endfunction

    always @(posedge clk) begin
        bit [31:0] s;
        if (!rst_n) begin
            m_latch = '0;
            m_lvl   = '0;
        end else begin
            s = sw_set;
            for (int k = 0; k < 16; k++)
                if (edge_cfg[k] && line_lvl[k] && !m_lvl[k]) s[16+k] = 1'b1;
            if (m_accept()) s[sgi_id] = 1'b1;
            m_latch = (m_latch | s) & ~sw_clr;
            m_lvl   = line_lvl;
        end
    end

    always @(negedge clk) begin
        bit [31:0] e;
        if (rst_n && !done) begin
            e = m_latch | {m_lvl & ~edge_cfg, 16'h0};
            checks++;
            if (pend_o !== e) begin
                failures++;
                $display("FAIL R4 model compare t=%0t actual=%h expected=%h", $time, pend_o, e);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] exp);
        checks++;
        if (pend_o !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, pend_o, exp);
        end
    endtask

    task automatic clear_all();
        sw_clr = '1;
        tick();
        sw_clr = '0;
    endtask

    task automatic sgi(input logic [1:0] g, input logic [3:0] id, input logic ns);
        sgi_vld = 1'b1; sgi_grp = g; sgi_id = id; sgi_ns = ns;
        tick();
        sgi_vld = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD*150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        chk("R1 in reset", 32'h0);
        rst_n = 1'b1;
        tick();
        chk("R1 after reset", 32'h0);

        // Edge mode on line 4 (interrupt 20)
        edge_cfg = 16'h0010;
        line_lvl = 16'h0010; tick();
        chk("R2 rising edge", 32'h0010_0000);
        line_lvl = 16'h0; tick();
        chk("R3 held after fall", 32'h0010_0000);
        sw_clr[20] = 1'b1; tick(); sw_clr = '0;
        chk("R6 clear", 32'h0);
        line_lvl = 16'h0010; tick();
        sw_clr[20] = 1'b1; tick(); sw_clr = '0;
        tick();
        chk("R2 steady high no reset", 32'h0);
        line_lvl = 16'h0; tick();
        chk("R2 falling edge", 32'h0);
        line_lvl = 16'h0010; sw_clr[20] = 1'b1; tick(); sw_clr = '0;
        chk("R6 clear beats edge", 32'h0);
        line_lvl = 16'h0; tick();

        // Level mode on line 9 (interrupt 25)
        line_lvl = 16'h0200; tick();
        chk("R4 level high", 32'h0200_0000);
        line_lvl = 16'h0; tick();
        chk("R4 level low", 32'h0);

        // Software set and clear
        sw_set[3] = 1'b1; tick(); sw_set = '0;
        chk("R5 software set", 32'h0000_0008);
        sw_set[3] = 1'b1; sw_clr[3] = 1'b1; tick(); sw_set = '0; sw_clr = '0;
        chk("R6 clear beats set", 32'h0);

        // Software requests, security enabled
        sgi(2'd0, 4'd2, 1'b0);
        chk("R10 accepted request", 32'h0000_0004); clear_all();
        sgi(2'd1, 4'd2, 1'b0);
        chk("R7 secure g1 onto g0", 32'h0000_0004); clear_all();
        sgi(2'd2, 4'd2, 1'b0);
        chk("R8 group mismatch", 32'h0);
        sgi(2'd3, 4'd2, 1'b0);
        chk("R8 code 3 dropped", 32'h0);
        sgi(2'd0, 4'd2, 1'b1);
        chk("R9 g0 perm 0", 32'h0);
        nsacc[5:4] = 2'd1;
        sgi(2'd0, 4'd2, 1'b1);
        chk("R9 g0 perm 1", 32'h0000_0004); clear_all();

        mod_cfg[5] = 1'b1;
        sgi(2'd0, 4'd5, 1'b0);
        chk("R8 g0 onto secure g1", 32'h0);
        nsacc[11:10] = 2'd1;
        sgi(2'd1, 4'd5, 1'b1);
        chk("R9 secure g1 perm 1", 32'h0);
        nsacc[11:10] = 2'd2;
        sgi(2'd1, 4'd5, 1'b1);
        chk("R9 secure g1 perm 2", 32'h0000_0020); clear_all();

        grp_cfg[7] = 1'b1;
        sgi(2'd2, 4'd7, 1'b1);
        chk("R9 ns g1 unchecked", 32'h0000_0080); clear_all();
        sgi(2'd1, 4'd7, 1'b0);
        chk("R8 secure g1 onto ns g1", 32'h0);

        sec_off = 1'b1; nsacc = '0;
        sgi(2'd0, 4'd5, 1'b1);
        chk("R7 modifier ignored when security off", 32'h0000_0020); clear_all();
        sec_off = 1'b0;

        sgi_grp = 2'd0; sgi_id = 4'd2; sgi_ns = 1'b0; sgi_vld = 1'b0; tick();
        chk("R11 invalid request ignored", 32'h0);
        sw_clr[2] = 1'b1; sgi(2'd0, 4'd2, 1'b0); sw_clr = '0;
        chk("R6 clear beats request", 32'h0);

        // Random phase against the model
        for (int n = 0; n < 3000; n++) begin
            line_lvl = 16'($urandom);
            if (n % 200 == 0) edge_cfg = 16'($urandom);
            sw_set   = ($urandom % 6 == 0) ? 32'($urandom) & 32'($urandom) : '0;
            sw_clr   = ($urandom % 4 == 0) ? 32'($urandom) : '0;
            sgi_vld  = 1'($urandom);
            sgi_grp  = 2'($urandom);
            sgi_id   = 4'($urandom);
            sgi_ns   = 1'($urandom);
            if (n % 300 == 0) begin
                grp_cfg = 16'($urandom); mod_cfg = 16'($urandom);
                nsacc = 32'($urandom); sec_off = ($urandom % 4 == 0);
            end
            tick();
        end

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule